// File: doc/BRIEF.md
# Register Stack Push/Pop Engine

This block carries out single-byte stack opcodes against a byte-addressed, little-endian data memory. It owns an eight-entry file of 32-bit registers. Entry 4 is the stack pointer, and the stack grows toward lower addresses. An opcode in the push group stores the selected register at the top of the stack. An opcode in the pop group loads the word at the top of the stack into the selected register.

Opcodes arrive one at a time on a valid/opcode pair. The engine raises `busy` while it works and pulses `done` when the operation has finished. It talks to a synchronous word-wide memory port that has byte-lane enables, and read data returns one cycle after a read request.

A load port lets the surrounding logic write any register while the engine is not busy. A combinational read port shows any register, and the stack pointer also has an output of its own.

Top module: `stk_engine`

## Requirements
- R1: After reset every register reads zero, `busy` and `done` are low, and neither `mem_we` nor `mem_re` is asserted.
- R2: Opcodes 0x50..0x57 are pushes and 0x58..0x5F are pops, and opcode bits 2:0 name the register. Any other opcode is ignored: no memory access, no register change and no `done`. The engine never asserts `mem_we` and `mem_re` together.
- R3: A push first lowers the stack pointer (register 4) by 4. It then writes the selected register's value to the new stack pointer address, with `mem_we` high and all lanes of `mem_be` set.
- R4: A push of register 4 stores the stack pointer value held before the decrement.
- R5: A pop reads the word at the current stack pointer, raises the stack pointer by 4, and writes the word into the selected register in the cycle the read data is valid.
- R6: A pop into register 4 leaves the stack pointer equal to the loaded word. The loaded word overrides the increment.
- R7: Memory words are little-endian. The byte at the word's address travels on bits 7:0 and the byte at address+3 on bits 31:24. So the bytes 0A 00 00 00 read back as 0x0000000A.
- R8: An accepted opcode makes `busy` high in the next cycle. `done` rises 2 cycles after acceptance for a push and 3 cycles after for a pop, and it stays high for one cycle. An opcode presented while `busy` is high is ignored.
- R9: The stack pointer wraps modulo 2^32. A push at 0x00000000 gives 0xFFFFFFFC, and a pop at 0xFFFFFFFC gives 0x00000000.
- R10: When `ld_en` is high while the engine is not busy, `ld_data` is written into register `ld_sel` at the next clock edge. `rd_data` always shows register `rd_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Opcode present |
| op_code | input | 8 | Opcode byte |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_addr | output | 32 | Byte address of the memory word |
| mem_wdata | output | 32 | Write data, little-endian |
| mem_be | output | 4 | Byte-lane write enables |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read request; data valid the next cycle |
| mem_rdata | input | 32 | Read data |
| ld_en | input | 1 | Register load strobe |
| ld_sel | input | 3 | Register to load |
| ld_data | input | 32 | Value to load |
| rd_sel | input | 3 | Register to show |
| rd_data | output | 32 | Selected register value |
| sp | output | 32 | Stack pointer (register 4) |

## Verification
Counting from the clock edge that accepts an opcode, a push writes memory and updates the stack pointer at the first following edge, and `done` is visible right after it. A pop issues its read at that same first edge, updates the stack pointer there too, and writes the destination register at the second edge, so `done` follows one cycle later. The bench drives on falling edges and counts falling edges until `done`, expecting exactly 2 for a push and 3 for a pop. It compares registers, the stack pointer and its own byte-array memory only after `done` has been seen. For ignored opcodes it waits several cycles and checks that `done` stayed low and that the memory access counters did not move.

// File: rtl/stk_pkg.sv
package stk_pkg;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned WORD_BYTES = WORD_W / 8;
  localparam logic [7:0]  PUSH_BASE  = 8'h50;
  localparam logic [7:0]  POP_BASE   = 8'h58;

  typedef enum logic [1:0] {K_NONE, K_PUSH, K_POP} op_kind_e;
  typedef enum logic [1:0] {S_IDLE, S_EXEC, S_WAIT, S_DONE} st_e;

  function automatic logic [WORD_W-1:0] sp_dec(input logic [WORD_W-1:0] s);
    return s - WORD_W'(WORD_BYTES);
  endfunction

  function automatic logic [WORD_W-1:0] sp_inc(input logic [WORD_W-1:0] s);
    return s + WORD_W'(WORD_BYTES);
  endfunction

  function automatic op_kind_e classify(input logic [7:0] op);
    if (op[7:3] == PUSH_BASE[7:3])     return K_PUSH;
    else if (op[7:3] == POP_BASE[7:3]) return K_POP;
    else                               return K_NONE;
  endfunction
endpackage

// File: rtl/stk_decode.sv
module stk_decode
  import stk_pkg::*;
#(
  parameter int unsigned SEL_W = 3
) (
  input  logic [7:0]       op_code,
  output op_kind_e         kind,
  output logic [SEL_W-1:0] sel
);
  always_comb begin
    kind = classify(op_code);
    sel  = op_code[SEL_W-1:0];
  end
endmodule

// File: rtl/stk_regfile.sv
module stk_regfile #(
  parameter int unsigned W     = 32,
  parameter int unsigned N     = 8,
  parameter int unsigned SP    = 4,
  localparam int unsigned SEL_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sp_we,
  input  logic [W-1:0]     sp_d,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [W-1:0]     wr_d,
  input  logic [SEL_W-1:0] rda_sel,
  output logic [W-1:0]     rda,
  input  logic [SEL_W-1:0] rdb_sel,
  output logic [W-1:0]     rdb,
  output logic [W-1:0]     sp_q
);
  logic [N-1:0][W-1:0] q;
  logic [N-1:0]        hit;

  for (genvar g = 0; g < N; g++) begin : g_hit
    assign hit[g] = wr_en && (wr_sel == SEL_W'(g));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (hit[i])                    q[i] <= wr_d;
        else if (i == SP && sp_we)     q[i] <= sp_d;
      end
    end
  end

  assign rda  = q[rda_sel];
  assign rdb  = q[rdb_sel];
  assign sp_q = q[SP];
endmodule

// File: rtl/stk_ctrl.sv
module stk_ctrl
  import stk_pkg::*;
#(
  parameter int unsigned W     = 32,
  parameter int unsigned SEL_W = 3,
  localparam int unsigned BE_W = W / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  op_kind_e         kind,
  input  logic [SEL_W-1:0] sel,
  input  logic [W-1:0]     sp_q,
  input  logic [W-1:0]     src_val,
  output logic [SEL_W-1:0] sel_q,
  output logic             busy,
  output logic             done,
  output logic             accept,
  output logic             nonstack_seen,
  output logic             push_fire,
  output logic             pop_fire,
  output logic             load_fire,
  output logic             sp_we,
  output logic [W-1:0]     sp_d,
  output logic [W-1:0]     mem_addr,
  output logic [W-1:0]     mem_wdata,
  output logic [BE_W-1:0]  mem_be,
  output logic             mem_we,
  output logic             mem_re
);
  st_e      state;
  op_kind_e kind_q;

  assign busy          = (state == S_EXEC) || (state == S_WAIT);
  assign done          = (state == S_DONE);
  assign accept        = op_valid && !busy && (kind != K_NONE);
  assign nonstack_seen = op_valid && !busy && (kind == K_NONE);
  assign push_fire     = (state == S_EXEC) && (kind_q == K_PUSH);
  assign pop_fire      = (state == S_EXEC) && (kind_q == K_POP);
  assign load_fire     = (state == S_WAIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      kind_q <= K_NONE;
      sel_q  <= '0;
    end else begin
      unique case (state)
        S_IDLE, S_DONE: begin
          if (accept) begin
            kind_q <= kind;
            sel_q  <= sel;
            state  <= S_EXEC;
          end else begin
            state  <= S_IDLE;
          end
        end
        S_EXEC:  state <= (kind_q == K_POP) ? S_WAIT : S_DONE;
        S_WAIT:  state <= S_DONE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    sp_we     = push_fire || pop_fire;
    sp_d      = push_fire ? sp_dec(sp_q) : sp_inc(sp_q);
    mem_addr  = push_fire ? sp_dec(sp_q) : sp_q;
    mem_wdata = src_val;
    mem_we    = push_fire;
    mem_re    = pop_fire;
    mem_be    = push_fire ? '1 : '0;
  end
endmodule

// File: rtl/stk_engine.sv
module stk_engine
  import stk_pkg::*;
#(
  parameter int unsigned DATA_W = stk_pkg::WORD_W,
  parameter int unsigned NREG   = 8,
  parameter int unsigned SP_IDX = 4,
  localparam int unsigned SEL_W = $clog2(NREG),
  localparam int unsigned BE_W  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [7:0]        op_code,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [BE_W-1:0]   mem_be,
  output logic              mem_we,
  output logic              mem_re,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              ld_en,
  input  logic [SEL_W-1:0]  ld_sel,
  input  logic [DATA_W-1:0] ld_data,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] sp
);
  op_kind_e            kind;
  logic [SEL_W-1:0]    sel, sel_q;
  logic [DATA_W-1:0]   sp_q, sp_d, src_val, wr_d;
  logic [SEL_W-1:0]    wr_sel;
  logic                sp_we, wr_en, accept, nonstack_seen;
  logic                push_fire, pop_fire, load_fire, host_load;

  stk_decode #(.SEL_W(SEL_W)) u_dec (
    .op_code(op_code), .kind(kind), .sel(sel)
  );

  stk_ctrl #(.W(DATA_W), .SEL_W(SEL_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .kind(kind), .sel(sel),
    .sp_q(sp_q), .src_val(src_val), .sel_q(sel_q), .busy(busy), .done(done),
    .accept(accept), .nonstack_seen(nonstack_seen), .push_fire(push_fire),
    .pop_fire(pop_fire), .load_fire(load_fire), .sp_we(sp_we), .sp_d(sp_d),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
    .mem_we(mem_we), .mem_re(mem_re)
  );

  // the memory return has priority; the host port only acts while idle
  assign host_load = ld_en && !busy;
  assign wr_en     = load_fire || host_load;
  assign wr_sel    = load_fire ? sel_q : ld_sel;
  assign wr_d      = load_fire ? mem_rdata : ld_data;

  stk_regfile #(.W(DATA_W), .N(NREG), .SP(SP_IDX)) u_rf (
    .clk(clk), .rst_n(rst_n), .sp_we(sp_we), .sp_d(sp_d),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_d(wr_d),
    .rda_sel(rd_sel), .rda(rd_data), .rdb_sel(sel_q), .rdb(src_val),
    .sp_q(sp_q)
  );

  assign sp = sp_q;
endmodule

// File: rtl/stk_engine_chk.sv
module stk_engine_chk
  import stk_pkg::*;
#(
  parameter int unsigned W     = 32,
  parameter int unsigned SEL_W = 3,
  parameter int unsigned SP    = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mem_we,
  input logic             mem_re,
  input logic [W/8-1:0]   mem_be,
  input logic [W-1:0]     mem_rdata,
  input logic             busy,
  input logic             done,
  input logic             accept,
  input logic             nonstack_seen,
  input logic             push_fire,
  input logic             pop_fire,
  input logic             load_fire,
  input logic [SEL_W-1:0] sel_q,
  input logic [W-1:0]     sp_q
);
  p_excl_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));
  p_ignore_r2: assert property (@(posedge clk) disable iff (!rst_n)
    nonstack_seen |=> !busy && !mem_we && !mem_re);
  p_push_sp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    push_fire |=> sp_q == $past(sp_q) - W'(4));
  p_pop_ret_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pop_fire |=> load_fire);
  p_pop_sp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (load_fire && sel_q == SEL_W'(SP)) |=> sp_q == $past(mem_rdata));
  p_lanes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_be == '1);
  p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind stk_engine stk_engine_chk #(.W(DATA_W), .SEL_W(SEL_W), .SP(SP_IDX)) i_chk (
  .clk(clk), .rst_n(rst_n), .mem_we(mem_we), .mem_re(mem_re), .mem_be(mem_be),
  .mem_rdata(mem_rdata), .busy(busy), .done(done), .accept(accept),
  .nonstack_seen(nonstack_seen), .push_fire(push_fire), .pop_fire(pop_fire),
  .load_fire(load_fire), .sel_q(sel_q), .sp_q(sp_q)
);

// File: tb/test_stk_engine.sv
module test_stk_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [7:0]  op_code = 8'h00;
  logic        busy, done, mem_we, mem_re;
  logic [31:0] mem_addr, mem_wdata, rd_data, sp;
  logic [31:0] mem_rdata = '0;
  logic [3:0]  mem_be;
  logic        ld_en = 1'b0;
  logic [2:0]  ld_sel = '0, rd_sel = '0;
  logic [31:0] ld_data = '0;

  int checks = 0, fails = 0, wr_cnt = 0, rd_cnt = 0;
  logic [7:0]  mem [1024];
  logic [31:0] mreg [8];

  always #10 clk = ~clk;

  stk_engine i_stk_engine (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .busy(busy), .done(done), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_be(mem_be), .mem_we(mem_we), .mem_re(mem_re), .mem_rdata(mem_rdata),
    .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data), .rd_sel(rd_sel),
    .rd_data(rd_data), .sp(sp)
  );

  // byte-array memory; the address wraps inside a 1 KiB window
  always @(posedge clk) begin
    if (mem_we) begin
      wr_cnt <= wr_cnt + 1;
      for (int b = 0; b < 4; b++)
        if (mem_be[b]) mem[(mem_addr[9:0] + 10'(b))] <= mem_wdata[8*b +: 8];
    end
    if (mem_re) begin
      rd_cnt <= rd_cnt + 1;
      mem_rdata <= {mem[mem_addr[9:0] + 10'd3], mem[mem_addr[9:0] + 10'd2],
                    mem[mem_addr[9:0] + 10'd1], mem[mem_addr[9:0]]};
    end
  end

  function automatic logic [31:0] word_at(input logic [31:0] a);
    logic [31:0] v = '0;
    for (int b = 3; b >= 0; b--) v = (v << 8) | 32'(mem[a[9:0] + 10'(b)]);
    return v;
  endfunction

  function automatic logic [31:0] lower_by_four(input logic [31:0] a);
    return a + 32'hFFFF_FFFC;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic read_reg(input int s, output logic [31:0] v);
    rd_sel = 3'(s);
    #1 v = rd_data;
  endtask

  task automatic load_reg(input int s, input logic [31:0] v);
    @(negedge clk);
    ld_en = 1'b1; ld_sel = 3'(s); ld_data = v;
    @(negedge clk);
    ld_en = 1'b0;
    mreg[s] = v;
  endtask

  task automatic run_op(input logic [7:0] op, output int cyc);
    @(negedge clk);
    op_valid = 1'b1; op_code = op;
    @(negedge clk);
    op_valid = 1'b0;
    cyc = 1;
    while (!done && cyc < 20) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  // one push or pop, checked against the bench model
  task automatic stack_op(input logic [7:0] op);
    int cyc, s, w0, r0;
    logic [31:0] v, exp_sp, exp_val, addr;
    s = int'(op[2:0]);
    w0 = wr_cnt; r0 = rd_cnt;
    if (op[3] == 1'b0) begin
      exp_val = mreg[s];
      exp_sp  = lower_by_four(mreg[4]);
      addr    = exp_sp;
      run_op(op, cyc);
      chk("R8 push latency", 32'(cyc), 32'd2);
      chk("R3 push store", word_at(addr), exp_val);
      chk("R3 push write count", 32'(wr_cnt - w0), 32'd1);
      mreg[4] = exp_sp;
    end else begin
      exp_val = word_at(mreg[4]);
      exp_sp  = (s == 4) ? exp_val : mreg[4] + 32'd4;
      run_op(op, cyc);
      chk("R8 pop latency", 32'(cyc), 32'd3);
      chk("R5 pop read count", 32'(rd_cnt - r0), 32'd1);
      mreg[4] = exp_sp;
      mreg[s] = exp_val;
      read_reg(s, v);
      chk("R5 pop dest", v, exp_val);
    end
    chk("R3/R5 stack pointer", sp, exp_sp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int cyc, w0, r0;
    logic [31:0] v;
    void'($urandom(32'd4242));
    for (int i = 0; i < 1024; i++) mem[i] = 8'($urandom);
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int i = 0; i < 8; i++) begin
      read_reg(i, v);
      chk("R1 reg reset", v, 32'd0);
      mreg[i] = '0;
    end
    chk("R1 busy/done/strobes", {28'd0, busy, done, mem_we, mem_re}, 32'd0);
    rst_n = 1'b1;

    // R10 load and read ports
    for (int i = 0; i < 8; i++) load_reg(i, 32'h1000_0000 * 32'(i) + 32'h55);
    load_reg(4, 32'h200);
    for (int i = 0; i < 8; i++) begin
      read_reg(i, v);
      chk("R10 load/read", v, mreg[i]);
    end

    // R3/R7 push with byte order
    load_reg(3, 32'h1122_3344);
    stack_op(8'h53);
    chk("R7 low byte at low address", 32'(mem[10'h1FC]), 32'h44);
    chk("R7 high byte at address+3", 32'(mem[10'h1FF]), 32'h11);

    // R4 push of the stack pointer keeps its old value
    stack_op(8'h54);
    chk("R4 pushed old sp", word_at(32'h1F8), 32'h1FC);

    // R7 bytes 0A 00 00 00 pop as 0x0000000A, R5 increment
    mem[10'h100] = 8'h0A; mem[10'h101] = 8'h00; mem[10'h102] = 8'h00; mem[10'h103] = 8'h00;
    load_reg(4, 32'h100);
    stack_op(8'h5B);
    chk("R7 little-endian load", mreg[3], 32'h0000_000A);
    chk("R5 sp after pop", sp, 32'h104);

    // R6 pop into the stack pointer
    mem[10'h104] = 8'h40; mem[10'h105] = 8'h02; mem[10'h106] = 8'h00; mem[10'h107] = 8'h00;
    stack_op(8'h5C);
    chk("R6 sp equals loaded word", sp, 32'h0000_0240);

    // R9 wrap in both directions
    load_reg(4, 32'h0);
    stack_op(8'h51);
    chk("R9 push wrap", sp, 32'hFFFF_FFFC);
    stack_op(8'h5A);
    chk("R9 pop wrap", sp, 32'h0);

    // R2 non-stack opcodes ignored
    foreach (mreg[i]) begin end
    for (int k = 0; k < 4; k++) begin
      logic [7:0] bad;
      bad = (k == 0) ? 8'h4F : (k == 1) ? 8'h60 : (k == 2) ? 8'h90 : 8'hFF;
      w0 = wr_cnt; r0 = rd_cnt;
      @(negedge clk); op_valid = 1'b1; op_code = bad;
      @(negedge clk); op_valid = 1'b0;
      cyc = 0;
      repeat (4) begin @(negedge clk); if (done || busy) cyc++; end
      chk("R2 ignored opcode no done/busy", 32'(cyc), 32'd0);
      chk("R2 ignored opcode no access", 32'((wr_cnt - w0) + (rd_cnt - r0)), 32'd0);
      for (int i = 0; i < 8; i++) begin
        read_reg(i, v);
        chk("R2 ignored opcode regs kept", v, mreg[i]);
      end
    end

    // R8 opcode while busy is ignored
    load_reg(4, 32'h300);
    w0 = wr_cnt; r0 = rd_cnt;
    @(negedge clk); op_valid = 1'b1; op_code = 8'h50;
    @(negedge clk); op_code = 8'h5E;          // busy now; this one must be dropped
    chk("R8 busy after accept", 32'(busy), 32'd1);
    @(negedge clk); op_valid = 1'b0;
    chk("R8 done pulse", 32'(done), 32'd1);
    @(negedge clk);
    chk("R8 done one cycle", 32'(done), 32'd0);
    repeat (3) @(negedge clk);
    chk("R8 busy opcode dropped", 32'((wr_cnt - w0) + (rd_cnt - r0)), 32'd1);
    mreg[4] = 32'h2FC;
    chk("R8 sp after single push", sp, 32'h2FC);

    // random mix
    load_reg(4, 32'h200);
    for (int n = 0; n < 400; n++) begin
      logic [7:0] op;
      if ($urandom_range(0, 9) == 0) load_reg(int'($urandom_range(0, 7)) == 4 ? 0 : int'($urandom_range(0, 3)), $urandom);
      op = 8'h50 | 8'($urandom_range(0, 15));
      if (op == 8'h5C) op = 8'h5D;
      stack_op(op);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule